// File: doc/BRIEF.md
# Single-Port Register-RAM Byte Datapath

This block is an 8-bit datapath. All programmer-visible registers live in one small RAM with a single write port. One ALU closes the loop between them: each step reads at most one register, passes it through the ALU with an optional second operand, and writes the result back into exactly one register. Multi-byte work is split into byte steps. This covers a program-counter increment and an indexed address calculation, each with a carry step that is taken only when needed. A small state machine runs the steps.

A controller issues a command made of an operation code, a source register index, a destination register index and an operand-source bit. The second ALU operand is either zero or an operand latch. That latch is filled from the memory data byte by a separate load strobe. Each write-back also updates the carry, zero and negative flags and a data-out latch.

The state machine has three states. IDLE waits for a command. STEP performs the first (or only) write-back. FIX performs the carry step on the high byte. Its transitions are:
- accept (IDLE to STEP): a valid command whose code is not 7.
- finish (STEP to IDLE): no carry step is needed.
- carry (STEP to FIX): an increment or index step produced a carry.
- settle (FIX to IDLE): the carry step has been written.

Top module: `regloop_datapath`

## Requirements
- R1: A synchronous reset clears every register location, the operand latch, the flags C, Z and N, and the data-out latch to zero. It also leaves busy and done low.
- R2: Register indices are 0 = PCL, 1 = PCH, 2 = SP, 3 = A, 4 = X and 5 = Y. A write to index 6 or 7 changes nothing, and a read of index 6 or 7 yields zero.
- R3: Code 0 (add) writes reg[rs] + operand + C to rd. Code 1 (copy) writes the operand latch to rd when src = 1, and reg[rs] when src = 0. Codes 2, 3 and 4 write reg[rs] AND, OR or XOR the operand to rd. The operand is the latch when src = 1 and zero when src = 0. Each of these codes takes one write-back step.
- R4: Every write-back step sets Z when the result is zero and sets N to the result's bit 7. C takes the carry-out of the adding steps (code 0, code 5, code 6 and the carry step). C is left unchanged by codes 1 to 4.
- R5: Code 5 (PC increment) ignores rs, rd and src. Its first step writes PCL + 1 back to PCL and captures the carry. Without a carry the command ends after that one step.
- R6: When the PCL step carries, code 5 takes exactly one more step. That step writes PCH + 1 to PCH, and C becomes the carry-out of PCH.
- R7: Code 6 (indexed address) writes reg[rs] + latch to rd with a carry-in of zero. If this carries, one extra step writes reg[t] + 1 to t, where t = (rd + 1) mod 8. With no carry, no extra step is taken.
- R8: The operand latch takes the memory data byte only when the load strobe is high. Memory data presented without the strobe, as during an opcode fetch, leaves it unchanged. A value loaded at the same clock edge that accepts a command is used by that command.
- R9: The data-out latch captures the ALU result at every write-back step and holds it while idle.
- R10: Busy is high from the cycle after a command is accepted until the final write-back edge. Done is high for exactly the one cycle that follows, with busy low.
- R11: Commands presented while busy are ignored, and so are commands with code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code (0 to 6; 7 is ignored) |
| cmd_rs | input | 3 | Source register index |
| cmd_rd | input | 3 | Destination register index |
| cmd_src | input | 1 | 1 selects the operand latch, 0 selects zero (or the register for copy) |
| mem_data | input | 8 | Memory data byte |
| opnd_load | input | 1 | Load strobe for the operand latch |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| alu_bus | output | 8 | ALU result bus |
| dout | output | 8 | Data-out latch |

## Verification
Suppose a command is accepted at clock edge k. Its first write-back lands at edge k+1. The carry step, when taken, lands at edge k+2. Done, the flags and the data-out latch then show the final result in the cycle after the last write-back. The bench drives and samples on falling edges. It counts the falling edges at which busy is high to get the step count, and it checks results at the first falling edge with busy low and again one cycle later. Register contents are read through the normal interface: a copy command sends the register to the ignored index 7, and the bench reads the data-out latch.

// File: rtl/regloop_pkg.sv
package regloop_pkg;

    typedef enum logic [2:0] {
        CMD_ADD   = 3'd0,
        CMD_COPY  = 3'd1,
        CMD_AND   = 3'd2,
        CMD_OR    = 3'd3,
        CMD_XOR   = 3'd4,
        CMD_PCINC = 3'd5,
        CMD_INDEX = 3'd6,
        CMD_NONE  = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_PASSA,
        ALU_PASSB,
        ALU_AND,
        ALU_OR,
        ALU_XOR
    } alu_e;

    typedef enum logic [1:0] {
        CIN_FLAG,
        CIN_ONE,
        CIN_ZERO
    } cin_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_FIX
    } state_e;

    localparam int unsigned IDX_PCL = 0;
    localparam int unsigned IDX_PCH = 1;

endpackage

// File: rtl/regloop_ram.sv
module regloop_ram #(
    parameter int unsigned DW   = 8,
    parameter int unsigned IW   = 3,
    parameter int unsigned NREG = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    logic [DW-1:0] word_q [NREG];
    logic [NREG-1:0] wsel;

    // per-word write decode; indices at or above NREG select nothing
    for (genvar i = 0; i < NREG; i++) begin : g_wsel
        assign wsel[i] = we && (waddr == IW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (wsel[i]) begin
                word_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == IW'(i)) begin
                rdata = word_q[i];
            end
        end
    end

endmodule

// File: rtl/regloop_alu.sv
module regloop_alu
    import regloop_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] y,
    output logic          cout
);

    logic [DW:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        cout = 1'b0;
        unique case (op)
            ALU_ADD: begin
                y    = sum[DW-1:0];
                cout = sum[DW];
            end
            ALU_PASSA: y = a;
            ALU_PASSB: y = b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            default:   y = a;
        endcase
    end

endmodule

// File: rtl/regloop_seq.sv
module regloop_seq
    import regloop_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_rs,
    input  logic [IW-1:0] cmd_rd,
    input  logic          cmd_src,
    input  logic          alu_cout,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] ram_raddr,
    output logic [IW-1:0] ram_waddr,
    output logic          ram_we,
    output alu_e          alu_op,
    output logic          b_from_latch,
    output cin_e          cin_mode,
    output logic          c_upd
);

    state_e        state_q, state_d;
    cmd_e          op_q;
    logic [IW-1:0] rs_q, rd_q;
    logic          src_q;
    logic          done_q;
    logic          accept;
    logic [IW-1:0] fix_tgt;

    assign accept = (state_q == ST_IDLE) && cmd_valid && (cmd_e'(cmd_op) != CMD_NONE);
    assign fix_tgt = (op_q == CMD_PCINC) ? IW'(IDX_PCH) : IW'(rd_q + 1'b1);

    // state register and command capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= CMD_NONE;
            rs_q    <= '0;
            rd_q    <= '0;
            src_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (accept) begin
                op_q  <= cmd_e'(cmd_op);
                src_q <= cmd_src;
                if (cmd_e'(cmd_op) == CMD_PCINC) begin
                    rs_q <= IW'(IDX_PCL);
                    rd_q <= IW'(IDX_PCL);
                end else begin
                    rs_q <= cmd_rs;
                    rd_q <= cmd_rd;
                end
            end
        end
    end

    // outputs and next state
    always_comb begin
        state_d      = state_q;
        ram_raddr    = rs_q;
        ram_waddr    = rd_q;
        ram_we       = 1'b0;
        alu_op       = ALU_PASSA;
        b_from_latch = 1'b0;
        cin_mode     = CIN_ZERO;
        c_upd        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_STEP;              // accept
                end
            end
            ST_STEP: begin
                ram_we  = 1'b1;
                state_d = ST_IDLE;                  // finish
                unique case (op_q)
                    CMD_ADD: begin
                        alu_op       = ALU_ADD;
                        b_from_latch = src_q;
                        cin_mode     = CIN_FLAG;
                        c_upd        = 1'b1;
                    end
                    CMD_COPY: begin
                        alu_op       = src_q ? ALU_PASSB : ALU_PASSA;
                        b_from_latch = 1'b1;
                    end
                    CMD_AND: begin
                        alu_op       = ALU_AND;
                        b_from_latch = src_q;
                    end
                    CMD_OR: begin
                        alu_op       = ALU_OR;
                        b_from_latch = src_q;
                    end
                    CMD_XOR: begin
                        alu_op       = ALU_XOR;
                        b_from_latch = src_q;
                    end
                    CMD_PCINC: begin
                        alu_op   = ALU_ADD;
                        cin_mode = CIN_ONE;
                        c_upd    = 1'b1;
                        if (alu_cout) begin
                            state_d = ST_FIX;       // carry
                        end
                    end
                    CMD_INDEX: begin
                        alu_op       = ALU_ADD;
                        b_from_latch = 1'b1;
                        cin_mode     = CIN_ZERO;
                        c_upd        = 1'b1;
                        if (alu_cout) begin
                            state_d = ST_FIX;       // carry
                        end
                    end
                    default: begin
                        ram_we = 1'b0;
                    end
                endcase
            end
            ST_FIX: begin
                ram_raddr = fix_tgt;
                ram_waddr = fix_tgt;
                ram_we    = 1'b1;
                alu_op    = ALU_ADD;
                cin_mode  = CIN_ONE;
                c_upd     = 1'b1;
                state_d   = ST_IDLE;                // settle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/regloop_datapath.sv
module regloop_datapath
    import regloop_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned IW   = 3,
    parameter int unsigned NREG = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_rs,
    input  logic [IW-1:0] cmd_rd,
    input  logic          cmd_src,
    input  logic [DW-1:0] mem_data,
    input  logic          opnd_load,
    output logic          busy,
    output logic          done,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_n,
    output logic [DW-1:0] alu_bus,
    output logic [DW-1:0] dout
);

    logic [IW-1:0] ram_raddr, ram_waddr;
    logic          ram_we;
    logic [DW-1:0] ram_rdata;
    alu_e          alu_op;
    logic          b_from_latch;
    cin_e          cin_mode;
    logic          c_upd;
    logic [DW-1:0] opnd_q, dout_q;
    logic [DW-1:0] alu_b, alu_y;
    logic          alu_cin, alu_cout;
    logic          fc_q, fz_q, fn_q;

    regloop_seq #(.IW(IW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_rs       (cmd_rs),
        .cmd_rd       (cmd_rd),
        .cmd_src      (cmd_src),
        .alu_cout     (alu_cout),
        .busy         (busy),
        .done         (done),
        .ram_raddr    (ram_raddr),
        .ram_waddr    (ram_waddr),
        .ram_we       (ram_we),
        .alu_op       (alu_op),
        .b_from_latch (b_from_latch),
        .cin_mode     (cin_mode),
        .c_upd        (c_upd)
    );

    regloop_ram #(.DW(DW), .IW(IW), .NREG(NREG)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .raddr (ram_raddr),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (alu_y)
    );

    assign alu_b = b_from_latch ? opnd_q : '0;

    always_comb begin
        unique case (cin_mode)
            CIN_FLAG: alu_cin = fc_q;
            CIN_ONE:  alu_cin = 1'b1;
            default:  alu_cin = 1'b0;
        endcase
    end

    regloop_alu #(.DW(DW)) u_alu (
        .op   (alu_op),
        .a    (ram_rdata),
        .b    (alu_b),
        .cin  (alu_cin),
        .y    (alu_y),
        .cout (alu_cout)
    );

    // operand latch: only the load strobe changes it
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (opnd_load) begin
            opnd_q <= mem_data;
        end
    end

    // flags and data-out latch follow each write-back
    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q   <= 1'b0;
            fz_q   <= 1'b0;
            fn_q   <= 1'b0;
            dout_q <= '0;
        end else if (ram_we) begin
            fz_q   <= (alu_y == '0);
            fn_q   <= alu_y[DW-1];
            dout_q <= alu_y;
            if (c_upd) begin
                fc_q <= alu_cout;
            end
        end
    end

    assign flag_c  = fc_q;
    assign flag_z  = fz_q;
    assign flag_n  = fn_q;
    assign alu_bus = alu_y;
    assign dout    = dout_q;

endmodule

// File: rtl/regloop_checker.sv
module regloop_checker #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          opnd_load,
    input logic [DW-1:0] mem_data,
    input logic [DW-1:0] opnd_q,
    input logic          flag_c,
    input logic          flag_z,
    input logic          flag_n,
    input logic [DW-1:0] dout
);

    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_two_steps_max_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !opnd_load |=> $stable(opnd_q));

    assert_latch_load_R8: assert property (@(posedge clk) disable iff (rst)
        opnd_load |=> (opnd_q == $past(mem_data)));

    assert_flags_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable({flag_c, flag_z, flag_n}));

    assert_dout_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(dout));

endmodule

bind regloop_datapath regloop_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .opnd_load (opnd_load),
    .mem_data  (mem_data),
    .opnd_q    (opnd_q),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .dout      (dout)
);

// File: tb/regloop_datapath_bench.sv
`timescale 1ns/1ps
module regloop_datapath_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_rs = 3'd0;
    logic [2:0] cmd_rd = 3'd0;
    logic       cmd_src = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic       opnd_load = 1'b0;
    logic       busy, done, flag_c, flag_z, flag_n;
    logic [7:0] alu_bus, dout;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] m [8];
    logic [7:0] lat;
    logic mc, mz, mn;

    always #2.5 clk = ~clk;

    regloop_datapath u_regloop_datapath (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rs(cmd_rs), .cmd_rd(cmd_rd), .cmd_src(cmd_src),
        .mem_data(mem_data), .opnd_load(opnd_load), .busy(busy), .done(done),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
        .alu_bus(alu_bus), .dout(dout)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rv(input logic [2:0] i);
        return (i < 3'd6) ? m[i] : 8'h00;
    endfunction

    task automatic wr(input logic [2:0] i, input logic [7:0] v);
        if (i < 3'd6) m[i] = v;
    endtask

    // issue one command with optional latch load at the accept edge, check everything
    task automatic issue(input logic [2:0] op, input logic [2:0] rs, input logic [2:0] rd,
                         input logic src, input bit ld, input logic [7:0] ldv, input string tag);
        logic [8:0] s;
        logic [7:0] y, b;
        logic [2:0] t;
        int exp_steps, steps;
        if (ld) lat = ldv;
        b = src ? lat : 8'h00;
        exp_steps = 1;
        y = 8'h00;
        case (op)
            3'd0: begin s = {1'b0, rv(rs)} + {1'b0, b} + {8'h00, mc}; y = s[7:0]; mc = s[8]; wr(rd, y); end
            3'd1: begin y = src ? lat : rv(rs); wr(rd, y); end
            3'd2: begin y = rv(rs) & b; wr(rd, y); end
            3'd3: begin y = rv(rs) | b; wr(rd, y); end
            3'd4: begin y = rv(rs) ^ b; wr(rd, y); end
            3'd5: begin
                s = {1'b0, m[0]} + 9'd1; y = s[7:0]; mc = s[8]; m[0] = y;
                if (mc) begin
                    s = {1'b0, m[1]} + 9'd1; y = s[7:0]; mc = s[8]; m[1] = y; exp_steps = 2;
                end
            end
            default: begin
                s = {1'b0, rv(rs)} + {1'b0, lat}; y = s[7:0]; mc = s[8]; wr(rd, y);
                if (mc) begin
                    t = rd + 3'd1;
                    s = {1'b0, rv(t)} + 9'd1; y = s[7:0]; mc = s[8]; wr(t, y); exp_steps = 2;
                end
            end
        endcase
        mz = (y == 8'h00);
        mn = y[7];
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_rs = rs; cmd_rd = rd; cmd_src = src;
        if (ld) begin opnd_load = 1'b1; mem_data = ldv; end
        @(negedge clk);
        cmd_valid = 1'b0; opnd_load = 1'b0;
        steps = 0;
        while (busy && steps < 8) begin
            steps++;
            @(negedge clk);
        end
        check({tag, " R10 done"}, {31'd0, done}, 32'd1);
        check({tag, " steps"}, steps, exp_steps);
        check({tag, " R9 dout"}, {24'd0, dout}, {24'd0, y});
        check({tag, " R4 flags"}, {29'd0, flag_c, flag_z, flag_n}, {29'd0, mc, mz, mn});
        @(negedge clk);
        check({tag, " R10 done low"}, {31'd0, done}, 32'd0);
    endtask

    task automatic load_latch(input logic [7:0] v);
        @(negedge clk);
        mem_data = v; opnd_load = 1'b1;
        @(negedge clk);
        opnd_load = 1'b0;
        lat = v;
    endtask

    task automatic set_reg(input logic [2:0] r, input logic [7:0] v);
        issue(3'd1, 3'd0, r, 1'b1, 1'b1, v, "R3 copy-in");
    endtask

    task automatic read_reg(input logic [2:0] r, input string tag);
        issue(3'd1, r, 3'd7, 1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        lat = 8'h00; mc = 0; mz = 0; mn = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 done", {31'd0, done}, 0);
        check("R1 flags", {29'd0, flag_c, flag_z, flag_n}, 0);
        check("R1 dout", {24'd0, dout}, 0);
        for (int r = 0; r < 8; r++) read_reg(3'(r), "R1 reg clear");
        issue(3'd1, 3'd0, 3'd7, 1'b1, 1'b0, 8'h00, "R1 latch clear");

        // R2 reserved indices
        for (int r = 0; r < 6; r++) set_reg(3'(r), 8'(8'h11 * (r + 1)));
        set_reg(3'd6, 8'h77);
        set_reg(3'd7, 8'h99);
        read_reg(3'd6, "R2 read 6");
        read_reg(3'd7, "R2 read 7");
        for (int r = 0; r < 6; r++) read_reg(3'(r), "R2 others kept");

        // R3 R4 sweep over operand pairs
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
                set_reg(3'd3, 8'(ai * 17));
                load_latch(8'((bi * 29 + 7) & 255));
                issue(3'd0, 3'd3, 3'd4, 1'b1, 1'b0, 8'h00, "R3 add");
                issue(3'd0, 3'd3, 3'd3, 1'b0, 1'b0, 8'h00, "R3 add carry only");
                issue(3'd2, 3'd3, 3'd5, 1'b1, 1'b0, 8'h00, "R3 and");
                issue(3'd3, 3'd3, 3'd2, 1'b1, 1'b0, 8'h00, "R3 or");
                issue(3'd4, 3'd3, 3'd4, 1'b1, 1'b0, 8'h00, "R3 xor");
                issue(3'd1, 3'd4, 3'd5, 1'b0, 1'b0, 8'h00, "R3 copy reg");
            end
        end

        // R5 R6 program-counter increment
        for (int pl = 0; pl < 4; pl++) begin
            for (int ph = 0; ph < 3; ph++) begin
                set_reg(3'd0, 8'(8'hFD + pl));
                set_reg(3'd1, (ph == 0) ? 8'h34 : (ph == 1) ? 8'h7F : 8'hFF);
                issue(3'd5, 3'd6, 3'd6, 1'b1, 1'b0, 8'h00, "R5 R6 pc increment");
                read_reg(3'd0, "R5 PCL");
                read_reg(3'd1, "R6 PCH");
            end
        end

        // R7 indexed address with page fix-up
        for (int xi = 0; xi < 18; xi++) begin
            for (int bi = 0; bi < 7; bi++) begin
                set_reg(3'd4, 8'(xi * 15));
                set_reg(3'd1, 8'(8'h40 + xi));
                load_latch(8'(bi * 37 + 3));
                issue(3'd6, 3'd4, 3'd0, 1'b1, 1'b0, 8'h00, "R7 index");
                read_reg(3'd0, "R7 low");
                read_reg(3'd1, "R7 high");
            end
        end
        set_reg(3'd5, 8'hF0);
        load_latch(8'h20);
        issue(3'd6, 3'd5, 3'd5, 1'b1, 1'b0, 8'h00, "R7 fix into reserved");

        // R8 latch holds without strobe, loads at accept edge
        load_latch(8'h5A);
        @(negedge clk);
        mem_data = 8'hC3;
        repeat (3) @(negedge clk);
        issue(3'd1, 3'd0, 3'd7, 1'b1, 1'b0, 8'h00, "R8 fetch ignored");
        issue(3'd1, 3'd0, 3'd7, 1'b1, 1'b1, 8'h81, "R8 load at accept");

        // R11 commands while busy and code 7
        set_reg(3'd0, 8'hFF);
        set_reg(3'd1, 8'h10);
        set_reg(3'd5, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5;
        @(negedge clk);
        cmd_op = 3'd1; cmd_rs = 3'd3; cmd_rd = 3'd5; cmd_src = 1'b0;
        @(negedge clk);
        check("R11 second step busy", {31'd0, busy}, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 done after pc", {31'd0, done}, 1);
        m[0] = 8'h00; m[1] = 8'h11; mc = 1'b0; mz = 1'b0; mn = 1'b0;
        @(negedge clk);
        check("R11 not accepted", {31'd0, busy}, 0);
        read_reg(3'd5, "R11 Y untouched");
        read_reg(3'd1, "R11 PCH");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd7; cmd_rs = 3'd3; cmd_rd = 3'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 code 7 ignored", {31'd0, busy}, 0);
        read_reg(3'd4, "R11 X untouched");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule